// File: doc/BRIEF.md
# Instruction Trace Address Filter

This block decides, in the same cycle that a retired instruction address is presented, whether that instruction should be traced. It holds a parameterised set of 64-bit address comparators. Neighbouring comparators can be combined into inclusive address ranges, and any single comparator can instead act as a start point or a stop point for a one-bit start/stop latch. Every comparator carries a mask of exception levels, split by security state, at which it is blind.

The final enable is the AND of three terms: an enabling-event selector, a range-include result, and the start/stop state when any start or stop comparator is selected. Software programs the comparators and control words through a simple write port. It reads the start/stop state back on a dedicated output and can preset it, for example to resume a trace region that was interrupted before its stop address was reached. Packet generation is left to a downstream unit.

Register map (index on `cfg_addr`): 0 = control (event selector in bits 7:0, start/stop state in bit 9), 1 = include mask, 2 = start/stop select, 0x20+i = value of comparator i, 0x40+i = exception-level mask of comparator i. The number of comparators must not exceed 16.

Top module: `trace_addr_filter`

## Requirements
- R1: After reset, every configuration word is zero, `ss_status` is 0, and `trace_en` is 0 for any input.
- R2: Tracing is possible only when control bits 7:0 equal 1, which selects the always-true resource; any other value blocks `trace_en`.
- R3: Comparators 2k and 2k+1 form range pair k, which matches when value(2k) <= address <= value(2k+1). Bit k of the include mask (index 1) makes pair k an include region, and an address then traces only if it lies in at least one selected pair.
- R4: When the include mask is zero, address ranges do not restrict tracing.
- R5: In the start/stop select word (index 2), bit i marks comparator i as a start point and bit 16+i marks it as a stop point. A comparator matches a start or stop point on exact address equality. A valid start match sets `ss_status` for the next cycle, and a valid stop match clears it.
- R6: When a start and a stop match on the same instruction, the stop wins: `ss_status` becomes 0 afterwards, while that instruction is still judged with the prior state ORed with the start match.
- R7: When the start/stop select word is zero, `ss_status` has no effect on `trace_en`.
- R8: A write to the control word loads bit 9 into `ss_status` on the next cycle, overriding any instruction-driven update in that cycle.
- R9: In a comparator's mask word (index 0x40+i), bit 12+e set suppresses its matches at non-secure exception level e, and bit 8+e set suppresses them at secure level e (`instr_ns` = 1 means non-secure). A range pair matches only when both of its comparators are not suppressed.
- R10: When `instr_valid` is 0, `trace_en` is 0 and `ss_status` does not change, except through a control-word write.
- R11: `trace_en` is 1 only when the event term, the range term and, with start/stop in use, the term (`ss_status` OR start match) are all true.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 7 | Configuration word index |
| cfg_wdata | input | 64 | Configuration write data |
| instr_valid | input | 1 | Retired instruction strobe |
| instr_addr | input | 64 | Retired instruction address |
| instr_el | input | 2 | Exception level of the instruction |
| instr_ns | input | 1 | 1 = non-secure, 0 = secure |
| trace_en | output | 1 | Trace this instruction (combinational) |
| ss_status | output | 1 | Start/stop state, 1 = started |

## Verification
The assertions take for granted that configuration writes and instructions are driven away from the clock edge and that `instr_valid` is a clean level. They also assume that a control-word write may coincide with a valid instruction, which is why the start, stop and hold properties exclude that cycle and a separate property covers the preset. The stimulus keeps `instr_valid` low during every configuration write, so the override case is covered only by the preset property and never competes with an instruction update. Start and stop comparators are placed on addresses distinct from the range bounds, so range and start/stop effects can be told apart at the output.

// File: rtl/tf_pkg.sv
package tf_pkg;

  localparam int unsigned CFG_AW   = 7;
  localparam int unsigned IDX_CTRL = 0;
  localparam int unsigned IDX_INCL = 1;
  localparam int unsigned IDX_SSEL = 2;
  localparam int unsigned IDX_VAL  = 32;
  localparam int unsigned IDX_ACC  = 64;
  localparam int unsigned STOP_SH  = 16;
  localparam int unsigned STAT_BIT = 9;
  localparam logic [7:0]  EV_ALWAYS = 8'd1;

  // Exception-level mask as stored: [7:4] non-secure levels 0..3, [3:0] secure.
  typedef logic [7:0] el_mask_t;

  function automatic logic el_visible(el_mask_t m, logic [1:0] el, logic ns);
    logic [2:0] idx;
    idx = {ns, el};
    return !m[idx];
  endfunction

  function automatic logic in_window(logic [63:0] a, logic [63:0] lo, logic [63:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

endpackage

// File: rtl/tf_cfg_regs.sv
module tf_cfg_regs
  import tf_pkg::*;
#(
  parameter int unsigned NUM_PAIRS = 4,
  parameter int unsigned ADDR_W    = 64,
  localparam int unsigned NUM_CMP  = 2 * NUM_PAIRS
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cfg_we,
  input  logic [CFG_AW-1:0]               cfg_addr,
  input  logic [63:0]                     cfg_wdata,
  output logic [7:0]                      ev_sel,
  output logic [NUM_PAIRS-1:0]            incl_mask,
  output logic [NUM_CMP-1:0]              start_sel,
  output logic [NUM_CMP-1:0]              stop_sel,
  output logic [NUM_CMP-1:0][ADDR_W-1:0]  cmp_val,
  output el_mask_t [NUM_CMP-1:0]          cmp_acc,
  output logic                            ctrl_wr
);

  assign ctrl_wr = cfg_we && (cfg_addr == CFG_AW'(IDX_CTRL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_sel    <= '0;
      incl_mask <= '0;
      start_sel <= '0;
      stop_sel  <= '0;
    end else if (cfg_we) begin
      if (cfg_addr == CFG_AW'(IDX_CTRL)) ev_sel <= cfg_wdata[7:0];
      if (cfg_addr == CFG_AW'(IDX_INCL)) incl_mask <= cfg_wdata[NUM_PAIRS-1:0];
      if (cfg_addr == CFG_AW'(IDX_SSEL)) begin
        start_sel <= cfg_wdata[NUM_CMP-1:0];
        stop_sel  <= cfg_wdata[STOP_SH +: NUM_CMP];
      end
    end
  end

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp_regs
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cmp_val[i] <= '0;
        cmp_acc[i] <= '0;
      end else if (cfg_we) begin
        if (cfg_addr == CFG_AW'(IDX_VAL + i)) cmp_val[i] <= cfg_wdata[ADDR_W-1:0];
        if (cfg_addr == CFG_AW'(IDX_ACC + i)) cmp_acc[i] <= cfg_wdata[15:8];
      end
    end
  end

endmodule

// File: rtl/tf_comparator.sv
module tf_comparator
  import tf_pkg::*;
#(
  parameter int unsigned ADDR_W = 64
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        el,
  input  logic              ns,
  input  logic [ADDR_W-1:0] value,
  input  el_mask_t          acc,
  output logic              visible,
  output logic              at_or_above,
  output logic              at_or_below,
  output logic              equal
);

  assign visible     = el_visible(acc, el, ns);
  assign at_or_above = addr >= value;
  assign at_or_below = addr <= value;
  assign equal       = addr == value;

endmodule

// File: rtl/tf_startstop.sv
module tf_startstop (
  input  logic clk,
  input  logic rst_n,
  input  logic instr_valid,
  input  logic start_hit,
  input  logic stop_hit,
  input  logic preset_we,
  input  logic preset_val,
  output logic status
);

  logic status_nxt;

  always_comb begin
    status_nxt = status;
    if (preset_we)                     status_nxt = preset_val;
    else if (instr_valid && stop_hit)  status_nxt = 1'b0;
    else if (instr_valid && start_hit) status_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= 1'b0;
    else        status <= status_nxt;
  end

endmodule

// File: rtl/trace_addr_filter.sv
module trace_addr_filter
  import tf_pkg::*;
#(
  parameter int unsigned NUM_PAIRS = 4,
  parameter int unsigned ADDR_W    = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [6:0]        cfg_addr,
  input  logic [63:0]       cfg_wdata,
  input  logic              instr_valid,
  input  logic [63:0]       instr_addr,
  input  logic [1:0]        instr_el,
  input  logic              instr_ns,
  output logic              trace_en,
  output logic              ss_status
);

  localparam int unsigned NUM_CMP = 2 * NUM_PAIRS;

  logic [7:0]                     ev_sel;
  logic [NUM_PAIRS-1:0]           incl_mask;
  logic [NUM_CMP-1:0]             start_sel;
  logic [NUM_CMP-1:0]             stop_sel;
  logic [NUM_CMP-1:0][ADDR_W-1:0] cmp_val;
  el_mask_t [NUM_CMP-1:0]         cmp_acc;
  logic                           ctrl_wr;

  logic [NUM_CMP-1:0]   c_vis, c_ge, c_le, c_eq;
  logic [NUM_CMP-1:0]   point_hit;
  logic [NUM_PAIRS-1:0] pair_hit;

  // Named internal events for the checker.
  logic event_ok;
  logic range_ok;
  logic ss_active;
  logic start_hit;
  logic stop_hit;
  logic ss_view;

  tf_cfg_regs #(.NUM_PAIRS(NUM_PAIRS), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .ev_sel    (ev_sel),
    .incl_mask (incl_mask),
    .start_sel (start_sel),
    .stop_sel  (stop_sel),
    .cmp_val   (cmp_val),
    .cmp_acc   (cmp_acc),
    .ctrl_wr   (ctrl_wr)
  );

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
    tf_comparator #(.ADDR_W(ADDR_W)) u_cmp (
      .addr        (instr_addr[ADDR_W-1:0]),
      .el          (instr_el),
      .ns          (instr_ns),
      .value       (cmp_val[i]),
      .acc         (cmp_acc[i]),
      .visible     (c_vis[i]),
      .at_or_above (c_ge[i]),
      .at_or_below (c_le[i]),
      .equal       (c_eq[i])
    );
    assign point_hit[i] = c_vis[i] && c_eq[i];
  end

  for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
    assign pair_hit[k] = c_vis[2*k] && c_vis[2*k+1] && c_ge[2*k] && c_le[2*k+1];
  end

  assign event_ok  = (ev_sel == EV_ALWAYS);
  assign range_ok  = (incl_mask == '0) || ((incl_mask & pair_hit) != '0);
  assign ss_active = (start_sel != '0) || (stop_sel != '0);
  assign start_hit = instr_valid && ((start_sel & point_hit) != '0);
  assign stop_hit  = instr_valid && ((stop_sel & point_hit) != '0);
  assign ss_view   = !ss_active || ss_status || start_hit;

  tf_startstop u_ss (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .start_hit   (start_hit),
    .stop_hit    (stop_hit),
    .preset_we   (ctrl_wr),
    .preset_val  (cfg_wdata[STAT_BIT]),
    .status      (ss_status)
  );

  assign trace_en = instr_valid && event_ok && range_ok && ss_view;

endmodule

// File: rtl/tf_checker.sv
module tf_checker (
  input logic clk,
  input logic rst_n,
  input logic instr_valid,
  input logic trace_en,
  input logic ss_status,
  input logic start_hit,
  input logic stop_hit,
  input logic ctrl_wr,
  input logic wr_status,
  input logic event_ok,
  input logic range_ok,
  input logic ss_active
);

  p_novalid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |-> !trace_en);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!instr_valid && !ctrl_wr) |=> $stable(ss_status));

  p_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && start_hit && !stop_hit && !ctrl_wr) |=> ss_status);

  p_stop_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && stop_hit && !ctrl_wr) |=> !ss_status);

  p_preset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (ss_status == $past(wr_status)));

  p_terms_r11: assert property (@(posedge clk) disable iff (!rst_n)
    trace_en |-> (event_ok && range_ok));

  p_ss_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (trace_en && ss_active) |-> (ss_status || start_hit));

endmodule

bind trace_addr_filter tf_checker u_tf_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .instr_valid (instr_valid),
  .trace_en    (trace_en),
  .ss_status   (ss_status),
  .start_hit   (start_hit),
  .stop_hit    (stop_hit),
  .ctrl_wr     (ctrl_wr),
  .wr_status   (cfg_wdata[9]),
  .event_ok    (event_ok),
  .range_ok    (range_ok),
  .ss_active   (ss_active)
);

// File: tb/trace_addr_filter_tb_top.sv
module trace_addr_filter_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [6:0]  cfg_addr = '0;
  logic [63:0] cfg_wdata = '0;
  logic        instr_valid = 1'b0;
  logic [63:0] instr_addr = '0;
  logic [1:0]  instr_el = '0;
  logic        instr_ns = 1'b1;
  logic        trace_en;
  logic        ss_status;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trace_addr_filter dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .instr_valid(instr_valid), .instr_addr(instr_addr),
    .instr_el(instr_el), .instr_ns(instr_ns), .trace_en(trace_en),
    .ss_status(ss_status)
  );

  // {addr, el, ns, valid, expected trace}
  localparam logic [68:0] VEC [11] = '{
    {64'h0000_0000_0000_0FFF, 2'd0, 1'b1, 1'b1, 1'b0},
    {64'h0000_0000_0000_1000, 2'd0, 1'b1, 1'b1, 1'b1},
    {64'h0000_0000_0000_1FFF, 2'd0, 1'b1, 1'b1, 1'b1},
    {64'h0000_0000_0000_2000, 2'd0, 1'b1, 1'b1, 1'b0},
    {64'h0000_0000_0000_8000, 2'd0, 1'b1, 1'b1, 1'b0},
    {64'h0000_0000_0000_1500, 2'd0, 1'b1, 1'b0, 1'b0},
    {64'h0000_0000_0000_1500, 2'd1, 1'b1, 1'b1, 1'b0},
    {64'h0000_0000_0000_1500, 2'd1, 1'b0, 1'b1, 1'b1},
    {64'h0000_0000_0000_1500, 2'd0, 1'b0, 1'b1, 1'b0},
    {64'h0000_0000_0000_1500, 2'd2, 1'b1, 1'b1, 1'b1},
    {64'hFFFF_FFFF_FFFF_1500, 2'd0, 1'b1, 1'b1, 1'b0}
  };

  task automatic check(input logic got, input logic exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [63:0] d);
    @(negedge clk);
    instr_valid = 1'b0;
    cfg_we = 1'b1; cfg_addr = 7'(idx); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_wdata = '0;
  endtask

  task automatic instr(input logic [63:0] a, input logic [1:0] el, input logic ns, input logic v);
    @(negedge clk);
    instr_addr = a; instr_el = el; instr_ns = ns; instr_valid = v;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    instr_valid = 1'b0;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    instr(64'h1500, 2'd0, 1'b1, 1'b1);
    check(trace_en, 1'b0, "R1 trace after reset");
    check(ss_status, 1'b0, "R1 status after reset");

    // Table setup: event always, pair0 [0x1000,0x1FFF], pair1 [0x8000,0x8000]
    wr(0, 64'h1);
    wr(32 + 0, 64'h1000);
    wr(32 + 1, 64'h1FFF);
    wr(32 + 2, 64'h8000);
    wr(32 + 3, 64'h8000);
    wr(64 + 0, 64'h2100);   // R9: NS EL1 and S EL0 blinded
    wr(64 + 1, 64'h2100);
    wr(1, 64'h1);

    // R3 R9 R10 table walk
    for (int i = 0; i < 11; i++) begin
      instr(VEC[i][68:5], VEC[i][4:3], VEC[i][2], VEC[i][1]);
      check(trace_en, VEC[i][0], $sformatf("R3/R9/R10 vector %0d", i));
    end

    // R3: select pair 1 only
    wr(1, 64'h2);
    instr(64'h8000, 2'd0, 1'b1, 1'b1);
    check(trace_en, 1'b1, "R3 pair1 hit");
    instr(64'h1500, 2'd0, 1'b1, 1'b1);
    check(trace_en, 1'b0, "R3 pair0 not selected");

    // R4: no include pairs
    wr(1, 64'h0);
    instr(64'h5000, 2'd0, 1'b1, 1'b1);
    check(trace_en, 1'b1, "R4 unrestricted");

    // R5: start cmp4 @0x3000, stop cmp5 @0x4000
    wr(32 + 4, 64'h3000);
    wr(32 + 5, 64'h4000);
    wr(2, (64'h1 << 4) | (64'h1 << 21));
    instr(64'h2000, 2'd0, 1'b1, 1'b1);
    check(trace_en, 1'b0, "R5 before start");
    instr(64'h3000, 2'd0, 1'b1, 1'b1);
    check(trace_en, 1'b1, "R5 start instr traced");
    idle();
    check(ss_status, 1'b1, "R5 started");
    instr(64'h2000, 2'd0, 1'b1, 1'b1);
    check(trace_en, 1'b1, "R5 inside region");
    instr(64'h4000, 2'd0, 1'b1, 1'b1);
    check(trace_en, 1'b1, "R5 stop instr uses prior state");
    idle();
    check(ss_status, 1'b0, "R5 stopped");
    instr(64'h2000, 2'd0, 1'b1, 1'b1);
    check(trace_en, 1'b0, "R5 after stop");

    // R10: invalid start address does nothing
    instr(64'h3000, 2'd0, 1'b1, 1'b0);
    check(trace_en, 1'b0, "R10 invalid no trace");
    idle();
    check(ss_status, 1'b0, "R10 invalid no state change");

    // R6: cmp6 @0x3000 as stop too
    wr(32 + 6, 64'h3000);
    wr(2, (64'h1 << 4) | (64'h1 << 21) | (64'h1 << 22));
    instr(64'h3000, 2'd0, 1'b1, 1'b1);
    check(trace_en, 1'b1, "R6 same-instr start traced");
    idle();
    check(ss_status, 1'b0, "R6 stop wins");

    // R8: preset status through control bit 9
    wr(0, 64'h201);
    check(ss_status, 1'b1, "R8 preset to started");
    instr(64'h2000, 2'd0, 1'b1, 1'b1);
    check(trace_en, 1'b1, "R8 preset resumes tracing");
    wr(0, 64'h001);
    check(ss_status, 1'b0, "R8 preset to stopped");
    instr(64'h2000, 2'd0, 1'b1, 1'b1);
    check(trace_en, 1'b0, "R8 cleared state blocks");

    // R11: range and start/stop combined; pair0 included, start cmp4 only
    wr(2, 64'h1 << 4);
    wr(1, 64'h1);
    instr(64'h1500, 2'd0, 1'b1, 1'b1);
    check(trace_en, 1'b0, "R11 in range, not started");
    instr(64'h3000, 2'd0, 1'b1, 1'b1);
    check(trace_en, 1'b0, "R11 start hit, out of range");
    idle();
    check(ss_status, 1'b1, "R11 started by out-of-range start");
    instr(64'h1500, 2'd0, 1'b1, 1'b1);
    check(trace_en, 1'b1, "R11 all terms true");

    // R7: no start/stop selected, state 0 ignored
    wr(1, 64'h0);
    wr(2, 64'h0);
    wr(0, 64'h001);
    instr(64'h2000, 2'd0, 1'b1, 1'b1);
    check(trace_en, 1'b1, "R7 start/stop unused");

    // R2: event selector other than 1
    wr(0, 64'h003);
    instr(64'h2000, 2'd0, 1'b1, 1'b1);
    check(trace_en, 1'b0, "R2 selector 3");
    wr(0, 64'h000);
    instr(64'h2000, 2'd0, 1'b1, 1'b1);
    check(trace_en, 1'b0, "R2 selector 0");

    // R1: reset in mid-run clears preset state and config
    wr(0, 64'h201);
    check(ss_status, 1'b1, "R1 pre-reset state");
    @(negedge clk);
    rst_n = 1'b0;
    instr_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(ss_status, 1'b0, "R1 reset clears state");
    instr(64'h2000, 2'd0, 1'b1, 1'b1);
    check(trace_en, 1'b0, "R1 reset clears event selector");

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule